// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave with Burst Indexing

This block receives control settings over a two-wire serial bus (I2C, write direction only) and hands them to an eight-entry register bank through a one-cycle write port. It runs entirely on the system clock. The SCL and SDA lines are oversampled through a two-flop synchronizer and a per-line glitch filter, and START and STOP are then recognised from the filtered levels. The block accepts a single chip address, acknowledges each accepted byte by pulling SDA low during the ninth clock, and then interprets the next byte as a register selector.

The selector byte carries a 3-bit register index in its low bits and a burst flag in bit 3; the top four bits are ignored. With the flag clear, exactly one data byte is written to the chosen register. With the flag set, successive data bytes go to successive registers, wrapping from the last back to the first, until a STOP or START closes the transfer. A START seen at any point, including halfway through a byte, abandons the current transfer and starts listening for an address again. Registers written before that point keep their values.

Top module: `i2c_ctl_slave`

## Requirements
- R1: After reset, sda_pull is 0 and wr_en is 0, and no write happens until a full addressed transfer arrives.
- R2: SDA falling while SCL is high is a START; SDA rising while SCL is high is a STOP. A START at any point, even with only some bits of a byte received, restarts address reception, and the incomplete byte is never written.
- R3: The first byte after START is 7 address bits (MSB first) then a direction bit. Only address 1010000 with direction 0 (byte value 0xA0) gets an ACK (sda_pull high during the ninth SCL high phase). Any other first byte gets no ACK, and all further bytes are ignored (no ACK, no write) until the next START or STOP.
- R4: After an accepted address, the selector byte and every data byte that is written are each acknowledged in their ninth clock.
- R5: In the selector byte, bits [2:0] give the register index, bit 3 gives the mode (0 single, 1 burst), and bits [7:4] have no effect.
- R6: In single mode the first data byte is written to the selected register; any later data byte in the same transfer gets no ACK and is not written.
- R7: In burst mode data bytes are written to the selected index, then index+1, and so on, wrapping from 7 to 0.
- R8: Each accepted data byte produces exactly one wr_en pulse of one clock, with wr_idx and wr_data valid in that cycle, issued after the eighth bit's SCL falling edge and before the ACK clock.
- R9: A level change on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored: it neither adds a bit nor forms a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level as seen at the pad |
| sda_in | input | 1 | Serial data line level as seen at the pad |
| sda_pull | output | 1 | 1 drives the data line low (acknowledge) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | IDX_W | Register index for the write |
| wr_data | output | 8 | Data byte for the write |

## Verification
The bench drives single-byte writes, a single-mode transfer with an extra trailing byte, and a burst that starts at index 6 so the wrap to 0 is seen; together these separate a correct index walk from a stuck or non-wrapping one and show that single mode refuses extra data. A wrong address and a read-direction byte are each followed by more bytes, showing that nothing is acknowledged or written after a rejected address. A START injected four bits into a data byte shows the half byte is dropped and a fresh transfer works, and short pulses on both lines within one byte show the filter keeps them from adding bits or forming bus conditions.

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int FILT_LEN = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam int MODE_BIT = IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} st_t;

  logic [1:0] meta, sync, filt;
  logic       scl_f, sda_f, scl_d, sda_d;
  logic       scl_rise, scl_fall, start_det, stop_det;

  st_t              state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             ack_ph, inc_mode, byte_done;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= 2'b11;
      sync <= 2'b11;
    end else begin
      meta <= {scl_in, sda_in};
      sync <= meta;
    end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        filt[g] <= 1'b1;
        cnt     <= '0;
      end else if (sync[g] == filt[g]) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        filt[g] <= sync[g];
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
  end

  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ack_ph    <= 1'b0;
      inc_mode  <= 1'b0;
      byte_done <= 1'b0;
      idx       <= '0;
      sda_pull  <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= S_ADDR;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= S_IDLE;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (state == S_ADDR || state == S_SUB || state == S_DATA) begin
        if (scl_rise && !ack_ph && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (ack_ph) begin
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            bitcnt   <= '0;
          end else if (bitcnt == 4'd8) begin
            case (state)
              S_ADDR:
                if (shreg == {DEV_ADDR, 1'b0}) begin
                  sda_pull <= 1'b1;
                  ack_ph   <= 1'b1;
                  state    <= S_SUB;
                end else begin
                  state <= S_SKIP;
                end
              S_SUB: begin
                sda_pull  <= 1'b1;
                ack_ph    <= 1'b1;
                idx       <= shreg[IDX_W-1:0];
                inc_mode  <= shreg[MODE_BIT];
                byte_done <= 1'b0;
                state     <= S_DATA;
              end
              S_DATA:
                if (inc_mode || !byte_done) begin
                  sda_pull  <= 1'b1;
                  ack_ph    <= 1'b1;
                  wr_en     <= 1'b1;
                  wr_idx    <= idx;
                  wr_data   <= shreg;
                  byte_done <= 1'b1;
                  if (inc_mode) idx <= idx + 1'b1;
                end else begin
                  state <= S_SKIP;
                end
              default: ;
            endcase
          end
        end
      end
    end

  p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_ADDR && bitcnt == 4'd0 && !sda_pull));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_pull));

  p_quiet_when_skipping_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_SKIP) |-> !sda_pull);

  p_single_keeps_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inc_mode) |-> idx == wr_idx);

  p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inc_mode) |-> idx == IDX_W'(wr_idx + 1'b1));

  p_write_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_write_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == S_DATA && sda_pull));

endmodule

// File: tb/i2c_ctl_slave_test.sv
module i2c_ctl_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 16;

  typedef struct packed {
    logic [2:0] idx;
    logic [7:0] data;
  } wr_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_pull, wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic       sda_bus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  wr_item_t expq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;

  i2c_ctl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [2:0] i, input logic [7:0] d);
    wr_item_t it;
    it.idx = i;
    it.data = d;
    expq.push_back(it);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1;
      if (glitch && i == 4) begin
        wq(6); m_sda = ~b[i]; wq(2); m_sda = b[i]; wq(2 * Q - 8);
      end else begin
        wq(2 * Q);
      end
      m_scl = 1'b0;
      if (glitch && i == 4) begin
        wq(4); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(Q - 6);
      end else begin
        wq(Q);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                           input bit glitch);
    send_bits(b, 8, glitch);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    check(sda_pull == exp_ack, req, int'(sda_pull), int'(exp_ack));
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3/R6 unexpected write", {wr_idx, wr_data}, 0);
      end else begin
        wr_item_t e;
        e = expq.pop_front();
        check(wr_idx == e.idx && wr_data == e.data, "R5/R7/R8 write content",
              {wr_idx, wr_data}, {e.idx, e.data});
      end
    end
  end

  initial begin
    wq(5);
    check(sda_pull == 1'b0, "R1 sda_pull in reset", int'(sda_pull), 0);
    check(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    wq(20);
    check(sda_pull == 1'b0 && wr_en == 1'b0, "R1 idle after reset",
          {sda_pull, wr_en}, 0);

    // R4 R6: single write to index 5
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 address ack", 1'b0);
    send_byte(8'h05, 1'b1, "R4 selector ack", 1'b0);
    push_exp(3'd5, 8'h3C);
    send_byte(8'h3C, 1'b1, "R4 data ack", 1'b0);
    bus_stop();

    // R5 don't-care high bits, R6 extra byte refused
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 address ack", 1'b0);
    send_byte(8'hF2, 1'b1, "R5 selector ack", 1'b0);
    push_exp(3'd2, 8'h81);
    send_byte(8'h81, 1'b1, "R6 first data ack", 1'b0);
    send_byte(8'h7E, 1'b0, "R6 extra byte no ack", 1'b0);
    bus_stop();

    // R7 burst from 6 wraps to 0
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 address ack", 1'b0);
    send_byte(8'h0E, 1'b1, "R4 selector ack", 1'b0);
    push_exp(3'd6, 8'h11);
    send_byte(8'h11, 1'b1, "R7 burst ack 6", 1'b0);
    push_exp(3'd7, 8'h22);
    send_byte(8'h22, 1'b1, "R7 burst ack 7", 1'b0);
    push_exp(3'd0, 8'h33);
    send_byte(8'h33, 1'b1, "R7 burst ack wrap 0", 1'b0);
    bus_stop();

    // R3 wrong address: everything after is ignored
    bus_start();
    send_byte(8'hA2, 1'b0, "R3 wrong address nack", 1'b0);
    send_byte(8'h08, 1'b0, "R3 ignored selector", 1'b0);
    send_byte(8'h55, 1'b0, "R3 ignored data", 1'b0);
    bus_stop();

    // R3 read direction refused
    bus_start();
    send_byte(8'hA1, 1'b0, "R3 read direction nack", 1'b0);
    send_byte(8'h66, 1'b0, "R3 ignored after read", 1'b0);
    bus_stop();

    // R2 START halfway through a data byte
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 address ack", 1'b0);
    send_byte(8'h09, 1'b1, "R4 selector ack", 1'b0);
    push_exp(3'd1, 8'h44);
    send_byte(8'h44, 1'b1, "R7 burst ack 1", 1'b0);
    send_bits(8'hF0, 4, 1'b0);
    bus_start();
    send_byte(8'hA0, 1'b1, "R2 address ack after restart", 1'b0);
    send_byte(8'h04, 1'b1, "R2 selector ack after restart", 1'b0);
    push_exp(3'd4, 8'h99);
    send_byte(8'h99, 1'b1, "R2 data ack after restart", 1'b0);
    bus_stop();

    // R9 short pulses on both lines inside a data byte
    bus_start();
    send_byte(8'hA0, 1'b1, "R3 address ack", 1'b0);
    send_byte(8'h0B, 1'b1, "R4 selector ack", 1'b0);
    push_exp(3'd3, 8'hA5);
    send_byte(8'hA5, 1'b1, "R9 glitched byte ack", 1'b1);
    push_exp(3'd4, 8'h5A);
    send_byte(8'h5A, 1'b1, "R9 following byte ack", 1'b0);
    bus_stop();

    wq(40);
    check(expq.size() == 0, "R8 all expected writes seen", expq.size(), 0);
    check(sda_pull == 1'b0, "R2 released after stop", int'(sda_pull), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule